// File: doc/BRIEF.md
# Serial Shift Interface Engine

This block is a small serial-communication engine for a microcontroller. It has an 8-bit shift register that the CPU reads and writes directly. The register has no holding copy, so each new byte replaces the last one. It also has a 4-bit edge counter and a detector for start conditions on a two-wire bus. Software picks the clock source: the serial clock pin, a timer compare strobe, or a strobe bit written in the control register. It also picks the line mode: off, three-wire (separate data-out, data-in and clock) or two-wire (open-drain data and clock).

The most significant bit of the shift register reaches the data output through a transparent latch. Input is sampled on the rising clock edge and the output changes after the falling edge. Serial input is always taken from the data-in/two-wire data pin. In two-wire mode the block raises a flag when it sees a start condition. It holds the clock line low while the start flag or the counter-overflow flag is pending, so software can service the byte before the bus moves on.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, the data, status and control registers read 0, and do_out, sda_oe, scl_oe, irq_start and irq_ovf are all 0.
- R2: The register map is: address 0 = shift register (read and write); address 1 = status, with bit 7 the start flag, bit 6 the overflow flag and bits 3:0 the counter; address 2 = control, with bit 7 the start interrupt enable, bit 6 the overflow interrupt enable, bits 5:4 the line mode, bits 3:2 the clock source and bit 0 the strobe. A status write loads the counter from bits 3:0 and clears each flag whose bit is written 1. The strobe bit always reads 0.
- R3: Each shift event moves the register one place toward the MSB. Bit 0 takes the synchronized level of sda_in, whatever the line mode.
- R4: With clock source 01 (pin), a rising edge of the synchronized scl_in shifts the register and advances the counter, and a falling edge only advances the counter. The output latch follows the MSB only while the clock is low, so do_out keeps its value while the clock is high and changes after the falling edge.
- R5: With clock source 10 (timer), each clock cycle in which tmr_match is high shifts the register and counts once. With clock source 00, neither pin edges nor tmr_match shift or count.
- R6: A control write with bit 0 set and bits 3:2 = 11 (software) shifts the register and counts exactly once. Bit 0 has no effect under any other clock source.
- R7: When the counter wraps from 15 to 0, the overflow flag is set. irq_ovf is the overflow flag ANDed with its enable.
- R8: In two-wire mode (bits 5:4 = 10), a falling synchronized sda while the synchronized clock is high sets the start flag. irq_start is the start flag ANDed with its enable. In three-wire mode (01), no start is detected.
- R9: In two-wire mode, scl_oe (clock pulled low) is asserted while the start flag or the overflow flag is set, and it is released when software clears them. scl_oe is never asserted in any other mode.
- R10: In three-wire mode, do_out equals the latched MSB and sda_oe is 0. In two-wire mode, sda_oe is the inverse of the latched MSB (it pulls low for a 0) and do_out is 0. With mode 00 or 11, all line outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select for reads and writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for addr |
| tmr_match | input | 1 | Timer compare strobe, used as a clock source |
| sda_in | input | 1 | Data-in pin, also the two-wire data line |
| sda_oe | output | 1 | Pull the two-wire data line low |
| scl_in | input | 1 | Serial clock pin |
| scl_oe | output | 1 | Pull the serial clock line low (hold) |
| do_out | output | 1 | Three-wire data output |
| irq_start | output | 1 | Start-condition interrupt request |
| irq_ovf | output | 1 | Counter-overflow interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit register, a 4-bit counter, a two-stage pin synchronizer and the output latch variant turned on. With these values, sixteen pin edges make up one byte and wrap the counter. The latch variant lets the bench show the half-cycle offset between sampling and output. The known three-cycle synchronizer latency sets when the bench samples each output. The bench models a wired-AND on both two-wire lines, so it can observe the clock hold and the open-drain data drive as they would appear on the bus.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

   typedef enum logic [1:0] {
      WM_OFF   = 2'b00,
      WM_THREE = 2'b01,
      WM_TWO   = 2'b10,
      WM_RSVD  = 2'b11
   } wire_mode_e;

   typedef enum logic [1:0] {
      CS_NONE  = 2'b00,
      CS_PIN   = 2'b01,
      CS_TIMER = 2'b10,
      CS_SOFT  = 2'b11
   } clk_src_e;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;

   localparam int BIT_START  = 7;
   localparam int BIT_OVF    = 6;
   localparam int BIT_STROBE = 0;
   localparam int MODE_LSB   = 4;
   localparam int SRC_LSB    = 2;

endpackage

// File: rtl/sxu_sync.sv
module sxu_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_prev
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sxu_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev <= RST_VAL;
      else        q_prev <= chain[STAGES-1];
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sxu_clkctl.sv
module sxu_clkctl
   import sxu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  clk_src_e   clk_src,
   input  wire_mode_e wire_mode,
   input  logic       scl_s,
   input  logic       scl_p,
   input  logic       sda_s,
   input  logic       sda_p,
   input  logic       tmr_match,
   input  logic       soft_strobe,
   output logic       shift_evt,
   output logic       count_evt,
   output logic       latch_open,
   output logic       start_evt
);

   logic scl_rise, scl_fall;

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;

   always_comb begin
      shift_evt  = soft_strobe;
      count_evt  = soft_strobe;
      latch_open = 1'b1;
      unique case (clk_src)
         CS_PIN: begin
            shift_evt  = soft_strobe | scl_rise;
            count_evt  = soft_strobe | scl_rise | scl_fall;
            latch_open = ~scl_s;
         end
         CS_TIMER: begin
            shift_evt = soft_strobe | tmr_match;
            count_evt = soft_strobe | tmr_match;
         end
         default: ;
      endcase
   end

   // start: data line falls while the clock stays high across both samples
   assign start_evt = (wire_mode == WM_TWO) & scl_s & scl_p & sda_p & ~sda_s;

   a_r4_fall_counts_only: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_src == CS_PIN && scl_p && !scl_s && !soft_strobe) |-> (!shift_evt && count_evt));

endmodule

// File: rtl/sxu_shifter.sv
module sxu_shifter #(
   parameter int DATA_W    = 8,
   parameter bit OUT_LATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_data,
   input  logic              shift_en,
   input  logic              ser_in,
   input  logic              latch_open,
   output logic [DATA_W-1:0] data_q,
   output logic              out_bit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (load_en)  data_q <= load_data;
      else if (shift_en) data_q <= {data_q[DATA_W-2:0], ser_in};
   end

   generate
      if (OUT_LATCH) begin : g_latch
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          hold_q <= 1'b0;
            else if (latch_open) hold_q <= data_q[DATA_W-1];
         end
         assign out_bit = hold_q;

         a_r4_latch_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !latch_open |=> out_bit == $past(out_bit));
      end else begin : g_direct
         assign out_bit = data_q[DATA_W-1];
      end
   endgenerate

   a_r3_shift_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en) |=> data_q[0] == $past(ser_in));

endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
   import sxu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_LATCH   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tmr_match,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic              scl_in,
   output logic              scl_oe,
   output logic              do_out,
   output logic              irq_start,
   output logic              irq_ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("serial_shift_unit: DATA_W must be at least 8");
      end
      if (CNT_W < 2 || CNT_W > DATA_W - 2) begin : g_bad_cnt
         $error("serial_shift_unit: CNT_W must fit below the status flags");
      end
   endgenerate

   logic scl_s, scl_p, sda_s, sda_p;
   logic shift_evt, count_evt, latch_open, start_evt;
   logic data_wr, stat_wr, ctrl_wr, soft_strobe;
   logic [DATA_W-1:0] data_q;
   logic out_bit;

   wire_mode_e mode_q;
   clk_src_e   src_q;
   logic       start_ie, ovf_ie;
   logic       start_flag, ovf_flag;
   logic [CNT_W-1:0] cnt_q;
   logic two_wire, three_wire, wrap;

   assign data_wr = wr_en && (addr == ADDR_DATA);
   assign stat_wr = wr_en && (addr == ADDR_STAT);
   assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
   assign soft_strobe = ctrl_wr && wr_data[BIT_STROBE] &&
                        (clk_src_e'(wr_data[SRC_LSB +: 2]) == CS_SOFT);

   sxu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s), .q_prev(scl_p));

   sxu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s), .q_prev(sda_p));

   sxu_clkctl u_clkctl (
      .clk(clk), .rst_n(rst_n), .clk_src(src_q), .wire_mode(mode_q),
      .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
      .tmr_match(tmr_match), .soft_strobe(soft_strobe),
      .shift_evt(shift_evt), .count_evt(count_evt),
      .latch_open(latch_open), .start_evt(start_evt));

   sxu_shifter #(.DATA_W(DATA_W), .OUT_LATCH(OUT_LATCH)) u_shifter (
      .clk(clk), .rst_n(rst_n), .load_en(data_wr), .load_data(wr_data),
      .shift_en(shift_evt), .ser_in(sda_s), .latch_open(latch_open),
      .data_q(data_q), .out_bit(out_bit));

   assign wrap = count_evt && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         start_flag <= 1'b0;
         ovf_flag   <= 1'b0;
         mode_q     <= WM_OFF;
         src_q      <= CS_NONE;
         start_ie   <= 1'b0;
         ovf_ie     <= 1'b0;
      end else begin
         if (stat_wr)        cnt_q <= wr_data[CNT_W-1:0];
         else if (count_evt) cnt_q <= cnt_q + 1'b1;
         ovf_flag   <= wrap | (ovf_flag & ~(stat_wr & wr_data[BIT_OVF]));
         start_flag <= start_evt | (start_flag & ~(stat_wr & wr_data[BIT_START]));
         if (ctrl_wr) begin
            start_ie <= wr_data[BIT_START];
            ovf_ie   <= wr_data[BIT_OVF];
            mode_q   <= wire_mode_e'(wr_data[MODE_LSB +: 2]);
            src_q    <= clk_src_e'(wr_data[SRC_LSB +: 2]);
         end
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (addr)
         ADDR_DATA: rd_data = data_q;
         ADDR_STAT: begin
            rd_data[BIT_START]  = start_flag;
            rd_data[BIT_OVF]    = ovf_flag;
            rd_data[CNT_W-1:0]  = cnt_q;
         end
         ADDR_CTRL: begin
            rd_data[BIT_START]         = start_ie;
            rd_data[BIT_OVF]           = ovf_ie;
            rd_data[MODE_LSB +: 2]     = mode_q;
            rd_data[SRC_LSB +: 2]      = src_q;
         end
         default: ;
      endcase
   end

   assign two_wire   = (mode_q == WM_TWO);
   assign three_wire = (mode_q == WM_THREE);
   assign do_out     = three_wire & out_bit;
   assign sda_oe     = two_wire & ~out_bit;
   assign scl_oe     = two_wire & (start_flag | ovf_flag);
   assign irq_start  = start_flag & start_ie;
   assign irq_ovf    = ovf_flag & ovf_ie;

   a_r2_counter_load: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> cnt_q == $past(wr_data[CNT_W-1:0]));

   a_r7_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (count_evt && cnt_q == CNT_MAX) |=> ovf_flag);

   a_r8_start_needs_two_wire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_flag) |-> $past(mode_q) == WM_TWO);

   a_r9_no_hold_outside_two_wire: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != WM_TWO) |-> !scl_oe);

   a_r10_three_wire_no_sda_pull: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == WM_THREE) |-> !sda_oe);

endmodule

// File: tb/tb_serial_shift_unit.sv
module tb_serial_shift_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] A_DATA = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_CTRL = 2'd2;
   // {tx byte, rx byte}
   localparam logic [15:0] VEC [4] = '{16'hA53C, 16'hFF00, 16'h00FF, 16'h817E};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic tmr_match = 1'b0;
   logic sda_drv = 1'b1;
   logic scl_drv = 1'b1;
   logic sda_line, scl_line;
   logic sda_oe, scl_oe, do_out, irq_start, irq_ovf;
   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = sda_oe ? 1'b0 : sda_drv;
   assign scl_line = scl_oe ? 1'b0 : scl_drv;

   serial_shift_unit dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .tmr_match(tmr_match), .sda_in(sda_line), .sda_oe(sda_oe),
      .scl_in(scl_line), .scl_oe(scl_oe), .do_out(do_out),
      .irq_start(irq_start), .irq_ovf(irq_ovf));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(A_DATA, v); check("R1 data", v, 8'h00);
      rd(A_STAT, v); check("R1 status", v, 8'h00);
      rd(A_CTRL, v); check("R1 control", v, 8'h00);
      check("R1 pins", {3'b0, do_out, sda_oe, scl_oe, irq_start, irq_ovf}, 8'h00);

      // R6/R7/R3 table: three-wire, software strobe, overflow irq enabled
      wr(A_CTRL, 8'h5C);
      rd(A_CTRL, v); check("R2 control readback", v, 8'h5C);
      foreach (VEC[n]) begin
         wr(A_DATA, VEC[n][15:8]);
         wr(A_STAT, 8'hC8);
         for (int i = 7; i >= 0; i--) begin
            sda_drv = VEC[n][i];
            tick(4);
            check("R10 do_out three-wire", {7'b0, do_out}, {7'b0, VEC[n][8+i]});
            wr(A_CTRL, 8'h5D);
         end
         tick(1);
         rd(A_DATA, v); check("R3 received byte", v, VEC[n][7:0]);
         rd(A_STAT, v); check("R7 overflow after 8 strobes", v, 8'h40);
         check("R7 irq_ovf enabled", {7'b0, irq_ovf}, 8'h01);
      end
      rd(A_CTRL, v); check("R2 strobe reads 0", v, 8'h5C);

      // R4 pin clock, three-wire
      scl_drv = 1'b0; sda_drv = 1'b1;
      wr(A_CTRL, 8'h14);
      tick(5);
      wr(A_DATA, 8'h5A);
      wr(A_STAT, 8'hC0);
      tick(3);
      check("R4 latch open when clock low", {7'b0, do_out}, 8'h00);
      scl_drv = 1'b1; tick(5);
      rd(A_DATA, v); check("R4 rise shifts", v, 8'hB5);
      check("R4 output held while clock high", {7'b0, do_out}, 8'h00);
      rd(A_STAT, v); check("R4 rise counts", v, 8'h01);
      scl_drv = 1'b0; tick(5);
      check("R4 output after falling edge", {7'b0, do_out}, 8'h01);
      rd(A_STAT, v); check("R4 fall counts", v, 8'h02);
      rd(A_DATA, v); check("R4 fall does not shift", v, 8'hB5);
      sda_drv = 1'b0;
      for (int k = 0; k < 7; k++) begin
         scl_drv = 1'b1; tick(5);
         scl_drv = 1'b0; tick(5);
      end
      rd(A_DATA, v); check("R3 pin byte", v, 8'h80);
      rd(A_STAT, v); check("R7 overflow after 16 edges", v, 8'h40);
      check("R7 irq_ovf gated by enable", {7'b0, irq_ovf}, 8'h00);

      // R5 timer source
      sda_drv = 1'b1;
      wr(A_CTRL, 8'h18);
      wr(A_DATA, 8'h01);
      wr(A_STAT, 8'hC0);
      tick(3);
      tmr_match = 1'b1; tick(3); tmr_match = 1'b0; tick(1);
      rd(A_DATA, v); check("R5 timer shifts", v, 8'h0F);
      rd(A_STAT, v); check("R5 timer counts", v, 8'h03);
      wr(A_CTRL, 8'h19); tick(1);
      rd(A_STAT, v); check("R6 strobe ignored under timer", v, 8'h03);
      rd(A_DATA, v); check("R6 strobe no shift under timer", v, 8'h0F);
      wr(A_CTRL, 8'h10);
      tmr_match = 1'b1; tick(2); tmr_match = 1'b0;
      scl_drv = 1'b1; tick(5); scl_drv = 1'b0; tick(5);
      rd(A_STAT, v); check("R5 no source no count", v, 8'h03);
      rd(A_DATA, v); check("R5 no source no shift", v, 8'h0F);

      // R8 no start detection in three-wire
      scl_drv = 1'b1; sda_drv = 1'b1; tick(5);
      sda_drv = 1'b0; tick(5);
      rd(A_STAT, v); check("R8 no start in three-wire", v & 8'h80, 8'h00);
      sda_drv = 1'b1; tick(5);

      // two-wire: start detect and hold
      wr(A_DATA, 8'hFF); tick(2);
      wr(A_STAT, 8'hC0);
      wr(A_CTRL, 8'hA4);
      tick(3);
      check("R10 two-wire releases data for 1", {7'b0, sda_oe}, 8'h00);
      check("R9 no hold idle", {7'b0, scl_oe}, 8'h00);
      sda_drv = 1'b0; tick(5);
      rd(A_STAT, v); check("R8 start flag", v & 8'h80, 8'h80);
      check("R8 irq_start", {7'b0, irq_start}, 8'h01);
      check("R9 hold after start", {7'b0, scl_oe}, 8'h01);
      wr(A_STAT, 8'h80); tick(5);
      check("R9 release after start clear", {7'b0, scl_oe}, 8'h00);
      rd(A_STAT, v); check("R8 start flag cleared", v & 8'h80, 8'h00);
      sda_drv = 1'b1; tick(5);
      scl_drv = 1'b0; tick(5);
      wr(A_STAT, 8'h4F); tick(2);
      check("R9 no hold before wrap", {7'b0, scl_oe}, 8'h00);
      scl_drv = 1'b1; tick(5);
      rd(A_STAT, v); check("R7 two-wire overflow", v & 8'h40, 8'h40);
      check("R9 hold after overflow", {7'b0, scl_oe}, 8'h01);
      wr(A_STAT, 8'h40); tick(5);
      check("R9 release after ovf clear", {7'b0, scl_oe}, 8'h00);

      // R10 open-drain data output
      scl_drv = 1'b0; tick(5);
      wr(A_DATA, 8'h00); tick(3);
      check("R10 two-wire pulls for 0", {7'b0, sda_oe}, 8'h01);
      check("R10 do_out idle in two-wire", {7'b0, do_out}, 8'h00);
      wr(A_DATA, 8'h80); tick(3);
      check("R10 two-wire releases for 1", {7'b0, sda_oe}, 8'h00);
      wr(A_DATA, 8'h00); tick(3);
      wr(A_CTRL, 8'h00); tick(2);
      check("R10 mode off outputs", {5'b0, do_out, sda_oe, scl_oe}, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule